// File: doc/BRIEF.md
# Supply low-voltage reset filter

This block is the digital side of a low-supply detector. An analog comparator, outside the block, reports each CPU clock cycle whether the supply sits below a chosen trip level. The block debounces that flag against supply noise and turns it into a system reset request. It also offers a status bit that software can poll. The filter is deliberately lopsided. A reset is raised only after a long unbroken run of low samples, and a single good sample drops it again. While the reset is held, the comparator is told to use a raised release threshold, so that the release carries hysteresis.

Two configuration inputs set the operating mode. With the module enable off, the block is idle and reports nothing. With the module enable on and the reset enable off, the block never resets the system, and software watches the supply through the status bit (polled mode). With both enables on, a sustained low supply forces a reset (forced-reset mode). A byte-wide status and control register sits on a simple synchronous bus. It holds a read-only status bit and a writable trip-level select bit, and that select bit drives the comparator's level choice.

The controller is a three-state machine:
- `ST_OFF`: module disabled.
- `ST_MONITOR`: enabled, no reset requested.
- `ST_RESET`: reset requested.

Its transitions are:
- `ST_OFF`→`ST_MONITOR`: the module enable is 1.
- `ST_MONITOR`→`ST_RESET`: the reset enable is 1 and the current sample completes a run of nine low samples.
- `ST_RESET`→`ST_MONITOR`: a sample of 0, or the reset enable is 0.
- any state→`ST_OFF`: the module enable is 0.

Top module: `lvr_filter_top`

## Requirements
- R1: After `rst_n` is released, `sys_rst_req`, `hyst_sel_o` and `trip_sel_o` are 0, and with `bus_sel`=1 and `below_trip`=0 `bus_rdata` reads 8'h00.
- R2: With both enables at 1, `sys_rst_req` rises at the rising edge that samples the ninth consecutive `below_trip`=1 (1 means the supply is below the trip level). It does not rise at the edge that samples only the eighth.
- R3: Any edge that samples `below_trip`=0 restarts the run count, so 8 lows, 1 high and then 8 lows give no reset, and a ninth low after that gives one.
- R4: While `sys_rst_req` is 1, a single edge that samples `below_trip`=0 clears it at that edge.
- R5: `hyst_sel_o` is 1 exactly while `sys_rst_req` is 1.
- R6: With `cfg_pwr_en`=1 and `cfg_rst_en`=0 (polled mode), `sys_rst_req` stays 0 however long the flag stays 1.
- R7: With `cfg_pwr_en`=0, `sys_rst_req` is 0 at the next edge and the status bit reads 0. The run count is held clear, so after enabling again a fresh run of nine lows is needed.
- R8: With `bus_sel`=1, `bus_rdata` bit 7 is the unfiltered current `below_trip` gated by `cfg_pwr_en`, in the same cycle. Bit 5 is the trip select, and every other bit reads 0. With `bus_sel`=0, `bus_rdata` is 8'h00.
- R9: An edge with `bus_sel`=1 and `bus_wr`=1 loads `bus_wdata` bit 5 into the trip select, which drives `trip_sel_o`. Writes to other bits are ignored, and a write with `bus_sel`=0 changes nothing.
- R10: The run count saturates and does not wrap. After 40 low samples in polled mode, setting `cfg_rst_en`=1 raises `sys_rst_req` at the very next edge that samples a low.
- R11: While in reset, an edge that samples `cfg_rst_en`=0 releases `sys_rst_req`, even if the flag is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pwr_en | input | 1 | Module enable configuration bit |
| cfg_rst_en | input | 1 | Reset-generation enable configuration bit |
| below_trip | input | 1 | Sampled comparator flag, 1 = supply below threshold |
| bus_sel | input | 1 | Register select from address decode |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_sel` |
| trip_sel_o | output | 1 | Trip-level select to the comparator |
| hyst_sel_o | output | 1 | Raised release-threshold select to the comparator |
| sys_rst_req | output | 1 | System reset request |

## Verification
`sys_rst_req` and `hyst_sel_o` are registered. They change at the same rising edge that samples the deciding flag value, so the ninth low raises them and a single high clears them at that edge. The bench drives each input 1 ns after an edge and compares these outputs 1 ns after the following edge. `bus_rdata` is combinational. It is compared in that same sampling window against the flag held at that moment and the trip select last written. Every stimulus step updates a small arithmetic model of run length, reset state and trip select before the comparison. Sweeping run lengths 0 to 12 under all four enable combinations places each threshold crossing on a known edge.

// File: rtl/lvr_pkg.sv
`timescale 1ns/1ps
package lvr_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_MONITOR = 2'd1,
        ST_RESET   = 2'd2
    } lvr_state_e;

endpackage

// File: rtl/lvr_run_counter.sv
`timescale 1ns/1ps
// Counts consecutive low-supply samples; saturates at the limit.
module lvr_run_counter #(
    parameter int LOW_COUNT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic low_flag,
    output logic run_hit
);
    localparam int CW = $clog2(LOW_COUNT + 1);
    localparam logic [CW-1:0] LIMIT   = CW'(LOW_COUNT);
    localparam logic [CW-1:0] PRE_LIM = CW'(LOW_COUNT - 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_d;

    always_comb begin
        if (!enable || !low_flag) begin
            run_d = '0;
        end else if (run_q >= LIMIT) begin
            run_d = LIMIT;
        end else begin
            run_d = run_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // The sample being taken now completes the required run.
    assign run_hit = enable && low_flag && (run_q >= PRE_LIM);

endmodule

// File: rtl/lvr_ctrl_fsm.sv
`timescale 1ns/1ps
module lvr_ctrl_fsm
    import lvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic rst_en,
    input  logic low_flag,
    input  logic run_hit,
    output logic rst_req,
    output logic hyst_sel
);
    lvr_state_e state_q;
    lvr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_en) begin
                    state_d = ST_MONITOR;
                end
            end
            ST_MONITOR: begin
                if (!pwr_en) begin
                    state_d = ST_OFF;
                end else if (rst_en && run_hit) begin
                    state_d = ST_RESET;
                end
            end
            ST_RESET: begin
                if (!pwr_en) begin
                    state_d = ST_OFF;
                end else if (!rst_en || !low_flag) begin
                    state_d = ST_MONITOR;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        rst_req  = 1'b0;
        hyst_sel = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                rst_req  = 1'b1;
                hyst_sel = 1'b1;
            end
            default: begin
                rst_req  = 1'b0;
                hyst_sel = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lvr_csr.sv
`timescale 1ns/1ps
// Status and control register: read-only status, writable trip select.
module lvr_csr #(
    parameter int DATA_W     = 8,
    parameter int STATUS_BIT = 7,
    parameter int TRIP_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status_in,
    output logic [DATA_W-1:0] rdata,
    output logic              trip_sel
);
    logic trip_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else if (sel && wr) begin
            trip_q <= wdata[TRIP_BIT];
        end
    end

    assign trip_sel = trip_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rd
        if (i == STATUS_BIT) begin : g_stat
            assign rdata[i] = sel & status_in;
        end else if (i == TRIP_BIT) begin : g_trip
            assign rdata[i] = sel & trip_q;
        end else begin : g_rsvd
            assign rdata[i] = 1'b0;
        end
    end

endmodule

// File: rtl/lvr_filter_top.sv
`timescale 1ns/1ps
module lvr_filter_top #(
    parameter int LOW_COUNT  = 9,
    parameter int DATA_W     = 8,
    parameter int STATUS_BIT = 7,
    parameter int TRIP_BIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pwr_en,
    input  logic              cfg_rst_en,
    input  logic              below_trip,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              trip_sel_o,
    output logic              hyst_sel_o,
    output logic              sys_rst_req
);
    logic run_hit;
    logic status_now;

    assign status_now = cfg_pwr_en & below_trip;

    lvr_run_counter #(.LOW_COUNT(LOW_COUNT)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_pwr_en),
        .low_flag (below_trip),
        .run_hit  (run_hit)
    );

    lvr_ctrl_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en   (cfg_pwr_en),
        .rst_en   (cfg_rst_en),
        .low_flag (below_trip),
        .run_hit  (run_hit),
        .rst_req  (sys_rst_req),
        .hyst_sel (hyst_sel_o)
    );

    lvr_csr #(
        .DATA_W     (DATA_W),
        .STATUS_BIT (STATUS_BIT),
        .TRIP_BIT   (TRIP_BIT)
    ) csr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (bus_sel),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .status_in (status_now),
        .rdata     (bus_rdata),
        .trip_sel  (trip_sel_o)
    );

endmodule

// File: rtl/lvr_filter_checker.sv
`timescale 1ns/1ps
module lvr_filter_checker #(
    parameter int LOW_COUNT  = 9,
    parameter int DATA_W     = 8,
    parameter int STATUS_BIT = 7,
    parameter int TRIP_BIT   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_pwr_en,
    input logic              cfg_rst_en,
    input logic              below_trip,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              trip_sel_o,
    input logic              hyst_sel_o,
    input logic              sys_rst_req
);
    localparam logic [DATA_W-1:0] KEEP =
        (DATA_W'(1) << STATUS_BIT) | (DATA_W'(1) << TRIP_BIT);

    int unsigned ch_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_run <= 0;
        end else if (!cfg_pwr_en || !below_trip) begin
            ch_run <= 0;
        end else if (ch_run < LOW_COUNT) begin
            ch_run <= ch_run + 1;
        end
    end

    // R2 / R3: a reset only starts after a full unbroken low run
    a_r2_needs_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> (ch_run >= LOW_COUNT));

    a_r4_single_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && !below_trip) |=> !sys_rst_req);

    a_r5_hyst_tracks_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hyst_sel_o == sys_rst_req);

    a_r6_polled_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_en |=> !sys_rst_req);

    a_r7_off_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pwr_en |=> !sys_rst_req);

    a_r7_off_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pwr_en |-> !bus_rdata[STATUS_BIT]);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~KEEP) == '0);

    a_r8_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));

    a_r9_trip_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trip_sel_o) |-> $past(bus_sel && bus_wr));

endmodule

bind lvr_filter_top lvr_filter_checker #(
    .LOW_COUNT  (LOW_COUNT),
    .DATA_W     (DATA_W),
    .STATUS_BIT (STATUS_BIT),
    .TRIP_BIT   (TRIP_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_pwr_en  (cfg_pwr_en),
    .cfg_rst_en  (cfg_rst_en),
    .below_trip  (below_trip),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .trip_sel_o  (trip_sel_o),
    .hyst_sel_o  (hyst_sel_o),
    .sys_rst_req (sys_rst_req)
);

// File: tb/lvr_filter_top_tb_top.sv
`timescale 1ns/1ps
module lvr_filter_top_tb_top;
    localparam int NLOW = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pwr_en = 1'b1;
    logic       cfg_rst_en = 1'b1;
    logic       below_trip = 1'b0;
    logic       bus_sel = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       trip_sel_o;
    logic       hyst_sel_o;
    logic       sys_rst_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model
    int m_run = 0;
    bit m_rst = 1'b0;
    bit m_trip = 1'b0;

    always #2 clk = ~clk;

    lvr_filter_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_pwr_en(cfg_pwr_en), .cfg_rst_en(cfg_rst_en),
        .below_trip(below_trip), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trip_sel_o(trip_sel_o),
        .hyst_sel_o(hyst_sel_o), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock step: drive flag, advance model at the edge, compare 1 ns later.
    task automatic step(input logic f, input string req);
        bit was_rst;
        logic [7:0] exp_rd;
        below_trip = f;
        @(posedge clk);
        was_rst = m_rst;
        if (bus_sel && bus_wr) m_trip = bus_wdata[5];
        if (!cfg_pwr_en || !f) m_run = 0;
        else if (m_run < 100) m_run++;
        if (!cfg_pwr_en)      m_rst = 1'b0;
        else if (was_rst)     m_rst = cfg_rst_en && f;
        else                  m_rst = cfg_rst_en && (m_run >= NLOW);
        #1;
        exp_rd = bus_sel ? {cfg_pwr_en & f, 1'b0, m_trip, 5'b0} : 8'h00;
        chk((was_rst && !f) ? "R4" : req, "sys_rst_req", int'(sys_rst_req), int'(m_rst));
        chk("R5", "hyst_sel_o", int'(hyst_sel_o), int'(m_rst));
        chk("R8", "bus_rdata", int'(bus_rdata), int'(exp_rd));
        chk("R9", "trip_sel_o", int'(trip_sel_o), int'(m_trip));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1", "sys_rst_req", int'(sys_rst_req), 0);
        chk("R1", "hyst_sel_o", int'(hyst_sel_o), 0);
        chk("R1", "trip_sel_o", int'(trip_sel_o), 0);
        chk("R1", "bus_rdata", int'(bus_rdata), 0);

        // Sweep enables and run lengths (R2, R6, R7)
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 2; r++) begin
                cfg_pwr_en = p[0];
                cfg_rst_en = r[0];
                for (int len = 0; len <= 12; len++) begin
                    for (int k = 0; k < len; k++)
                        step(1'b1, (p == 0) ? "R7" : (r == 0) ? "R6" : "R2");
                    step(1'b0, "R4");
                    step(1'b0, "R4");
                end
            end
        end

        // R3: a high sample restarts the count
        cfg_pwr_en = 1'b1; cfg_rst_en = 1'b1;
        for (int k = 0; k < 8; k++) step(1'b1, "R3");
        step(1'b0, "R3");
        for (int k = 0; k < 8; k++) step(1'b1, "R3");
        chk("R3", "no reset after 8", int'(sys_rst_req), 0);
        step(1'b1, "R3");
        chk("R3", "reset after 9", int'(sys_rst_req), 1);
        step(1'b0, "R4");
        chk("R4", "released", int'(sys_rst_req), 0);

        // R10 saturation then R11 release on reset-enable drop
        cfg_rst_en = 1'b0;
        for (int k = 0; k < 40; k++) step(1'b1, "R6");
        cfg_rst_en = 1'b1;
        step(1'b1, "R10");
        chk("R10", "reset after saturated run", int'(sys_rst_req), 1);
        step(1'b1, "R10");
        cfg_rst_en = 1'b0;
        step(1'b1, "R11");
        chk("R11", "released by reset enable", int'(sys_rst_req), 0);

        // R7: disabled module holds count clear
        cfg_rst_en = 1'b1;
        for (int k = 0; k < 5; k++) step(1'b1, "R2");
        cfg_pwr_en = 1'b0;
        for (int k = 0; k < 20; k++) step(1'b1, "R7");
        cfg_pwr_en = 1'b1;
        for (int k = 0; k < 8; k++) step(1'b1, "R7");
        chk("R7", "fresh run needed", int'(sys_rst_req), 0);
        step(1'b1, "R7");
        chk("R7", "reset after fresh 9", int'(sys_rst_req), 1);
        step(1'b0, "R4");

        // R9 register writes
        bus_wr = 1'b1; bus_wdata = 8'hDF; step(1'b1, "R9");
        bus_wdata = 8'h20; step(1'b1, "R9");
        bus_wr = 1'b0; step(1'b1, "R9");
        chk("R9", "readback", int'(bus_rdata), 8'hA0);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h00; step(1'b0, "R9");
        chk("R8", "unselected read", int'(bus_rdata), 0);
        bus_sel = 1'b1; bus_wr = 1'b0; step(1'b0, "R9");
        chk("R9", "unselected write ignored", int'(trip_sel_o), 1);
        bus_wr = 1'b1; bus_wdata = 8'hDF; step(1'b0, "R9");
        bus_wr = 1'b0; step(1'b0, "R9");
        chk("R9", "cleared", int'(bus_rdata), 0);
        // R8 same-cycle status
        below_trip = 1'b1; #1;
        chk("R8", "status same cycle", int'(bus_rdata), 8'h80);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule